// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Front End

This block sits between a processor bus and a four-input successive-approximation converter. Software writes one control word. That word holds an interrupt enable, a repeat bit and a 5-bit input select. The block then sends the converter a one-cycle start pulse and the 2-bit input number, and waits for the converter's done pulse. On that pulse it captures the 8-bit result into a read-only data register.

Completion is reported in one of two ways, chosen by the interrupt enable. With the enable clear, a sticky completion flag is set. With the enable set, an interrupt line is raised instead. Reading the data register clears whichever one was set. Rewriting the control word while a conversion is running abandons that conversion, and its result is never stored.

The converter port carries no handshake. A done pulse is always taken in the cycle it arrives, so there is no back-pressure toward the converter. The converter is expected to restart whenever it sees a new start pulse.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the control word reads 0x1F: flag bit 7 = 0, interrupt enable bit 6 = 0, repeat bit 5 = 0, select bits 4..0 all ones. The data register reads 0x00, and both `irq` and `cnv_start` are low.
- R2: Address 0 selects the control word and address 1 the data register. Any other address reads 0x00. `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value until the next read. Writes to any address other than 0 change nothing.
- R3: With bit 6 = 0, the end of an accepted conversion sets bit 7 of the control readback. Reading the control word does not clear it; reading the data register does. The value written to bit 7 is ignored.
- R4: With bit 6 = 1, bit 7 always reads 0. The end of each accepted conversion instead raises `irq`.
- R5: `irq` is cleared by a read of the data register or by any write to the control word.
- R6: With bit 5 = 0, one conversion runs and no further start follows. With bit 5 = 1, a new start is issued in the cycle after each accepted done, and the data register is updated at every completion.
- R7: A control write whose select code is 0..3 drives `cnv_start` high for the following cycle, with `cnv_chan` equal to the code. Codes 4..31 (31 meaning powered down) issue no start and leave the sequencer idle.
- R8: A control write during a conversion discards it: neither data, flag nor `irq` changes when its done arrives. This also holds when the write falls in the same cycle as the done pulse.
- R9: When a data-register read and an accepted done coincide, the read returns the old data, the new result is stored, and the flag or `irq` stays set.
- R10: A done pulse arriving while no conversion is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared by the bus side and the converter port |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Completion interrupt request |
| cnv_start | output | 1 | One-cycle start pulse to the converter |
| cnv_chan | output | $clog2(NUM_CH) | Input selected for the conversion |
| cnv_done | input | 1 | Result-valid pulse from the converter |
| cnv_result | input | 8 | Conversion result, valid with `cnv_done` |

## Verification
The hardest conditions to reach are the same-cycle collisions. One is a done pulse arriving together with a data-register read. The other is a done pulse arriving together with a control rewrite. Both must land on one exact edge.

The bench plays the converter itself, with a fixed 16-cycle latency. It polls for the done pulse at mid-cycle and raises the bus strobe within that same cycle, so both events meet at the next edge. Abandoned conversions are provoked by rewriting the control word a few cycles after a start. The bench then lets the converter's stale done arrive against an idle sequencer, and it also injects an extra done pulse on its own.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W  = 8;
  localparam int SEL_FW = 5;

  localparam logic [SEL_FW-1:0] SEL_RESET = 5'h1F;

  typedef struct packed {
    logic              ien;
    logic              rep;
    logic [SEL_FW-1:0] sel;
  } ctl_word_t;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_t;
endpackage

// File: rtl/adc_seq_busif.sv
module adc_seq_busif
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_W-1:0]  ctl_view,
  input  logic [REG_W-1:0]  data_view,
  output logic              wr_ctl,
  output logic              rd_dat,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(1);

  logic hit_ctl;
  logic hit_dat;

  assign hit_ctl = (addr == A_CTL);
  assign hit_dat = (addr == A_DAT);
  assign wr_ctl  = wr && hit_ctl;
  assign rd_dat  = rd && hit_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (hit_ctl)      rdata <= ctl_view;
      else if (hit_dat) rdata <= data_view;
      else              rdata <= '0;
    end
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             rd_dat,
  input  logic             accept,
  input  logic [REG_W-1:0] result,
  output ctl_word_t        ctl,
  output logic [REG_W-1:0] data_q,
  output logic             flag_vis,
  output logic             irq
);
  logic flag_q;
  logic flag_write_unused;

  // the completion flag is read-only: bit 7 of a write goes nowhere
  assign flag_write_unused = wdata[REG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '{ien: 1'b0, rep: 1'b0, sel: SEL_RESET};
    end else if (wr_ctl) begin
      ctl <= ctl_word_t'(wdata[REG_W-2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= result;
    end
  end

  // a completion outranks a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (accept && !ctl.ien) begin
      flag_q <= 1'b1;
    end else if (rd_dat) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (accept && ctl.ien) begin
      irq <= 1'b1;
    end else if (rd_dat || wr_ctl) begin
      irq <= 1'b0;
    end
  end

  assign flag_vis = flag_q && !ctl.ien;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [SEL_FW-1:0] new_sel,
  input  logic              rep,
  input  logic              cnv_done,
  output logic              cnv_start,
  output logic [SEL_W-1:0]  cnv_chan,
  output logic              accept
);
  localparam logic [SEL_FW-1:0] CH_LIMIT = SEL_FW'(NUM_CH);

  sq_state_t state;
  logic      code_ok;

  assign code_ok = (new_sel < CH_LIMIT);
  // a control write in the done cycle wins and discards the result
  assign accept  = (state == SQ_RUN) && cnv_done && !wr_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cnv_start <= 1'b0;
      cnv_chan  <= '0;
    end else begin
      cnv_start <= 1'b0;
      if (wr_ctl) begin
        if (code_ok) begin
          state     <= SQ_RUN;
          cnv_start <= 1'b1;
          cnv_chan  <= new_sel[SEL_W-1:0];
        end else begin
          state <= SQ_IDLE;
        end
      end else if (accept) begin
        if (rep) begin
          cnv_start <= 1'b1;
        end else begin
          state <= SQ_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              cnv_start,
  output logic [SEL_W-1:0]  cnv_chan,
  input  logic              cnv_done,
  input  logic [REG_W-1:0]  cnv_result
);
  logic             wr_ctl;
  logic             rd_dat;
  logic             accept;
  logic             flag_vis;
  ctl_word_t        ctl;
  logic [REG_W-1:0] data_q;
  logic [REG_W-1:0] ctl_view;

  assign ctl_view = {flag_vis, ctl};

  adc_seq_busif #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .ctl_view  (ctl_view),
    .data_view (data_q),
    .wr_ctl    (wr_ctl),
    .rd_dat    (rd_dat),
    .rdata     (bus_rdata)
  );

  adc_seq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctl   (wr_ctl),
    .wdata    (bus_wdata),
    .rd_dat   (rd_dat),
    .accept   (accept),
    .result   (cnv_result),
    .ctl      (ctl),
    .data_q   (data_q),
    .flag_vis (flag_vis),
    .irq      (irq)
  );

  adc_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_ctl),
    .new_sel   (bus_wdata[SEL_FW-1:0]),
    .rep       (ctl.rep),
    .cnv_done  (cnv_done),
    .cnv_start (cnv_start),
    .cnv_chan  (cnv_chan),
    .accept    (accept)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [4:0]        wsel,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              cnv_start,
  input logic [SEL_W-1:0]  cnv_chan,
  input logic              cnv_done
);
  localparam logic [4:0] CH_LIMIT = 5'(NUM_CH);

  logic wr_c;
  logic rd_c;
  logic rd_d;
  assign wr_c = bus_wr && (bus_addr == ADDR_W'(0));
  assign rd_c = bus_rd && (bus_addr == ADDR_W'(0));
  assign rd_d = bus_rd && (bus_addr == ADDR_W'(1));

  AST_START_ON_VALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && wsel < CH_LIMIT) |=> (cnv_start && cnv_chan == $past(wsel[SEL_W-1:0]))); // R7
  AST_NO_START_ON_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && wsel >= CH_LIMIT) |=> !cnv_start); // R7
  AST_IRQ_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> !irq); // R5
  AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_d && !cnv_done) |=> !irq); // R5
  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> !(bus_rdata[7] && bus_rdata[6])); // R4
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnv_done)); // R4
  AST_START_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_start && !wr_c && !cnv_done) |=> !cnv_start); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
endmodule

bind adc_seq_top adc_seq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .wsel      (bus_wdata[4:0]),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnv_start (cnv_start),
  .cnv_chan  (cnv_chan),
  .cnv_done  (cnv_done)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
  localparam int LAT = 16;
  localparam int NV  = 7;
  // {write data, expected control readback, expected start}
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b1},
    {8'h03, 8'h03, 1'b1},
    {8'h1F, 8'h1F, 1'b0},
    {8'h04, 8'h04, 1'b0},
    {8'h80, 8'h00, 1'b1},
    {8'h62, 8'h62, 1'b1},
    {8'h35, 8'h35, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       cnv_start;
  logic [1:0] cnv_chan;
  logic       cnv_done;
  logic [7:0] cnv_result;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq(irq), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
    .cnv_done(cnv_done), .cnv_result(cnv_result)
  );

  // converter stand-in: restarts on every start, done LAT cycles later
  logic [4:0] m_cnt;
  logic [1:0] m_ch;
  logic [5:0] m_seq;
  logic       m_done;
  logic [7:0] m_res;
  logic       spur = 1'b0;
  assign cnv_done   = m_done | spur;
  assign cnv_result = m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_ch <= '0; m_seq <= '0; m_done <= 1'b0; m_res <= '0;
    end else begin
      m_done <= 1'b0;
      if (cnv_start) begin
        m_cnt <= 5'(LAT);
        m_ch  <= cnv_chan;
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 5'd1;
        if (m_cnt == 5'd1) begin
          m_done <= 1'b1;
          m_res  <= {m_ch, m_seq};
          m_seq  <= m_seq + 6'd1;
        end
      end
    end
    if (rst_n && cnv_start) n_start++;
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 64; i++) begin
      if (cnv_done) break;
      tick();
    end
    chk("done seen", {7'd0, cnv_done}, 8'h01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] e;
    logic [7:0] exp_data;
    int s0;
    tick(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 start", {7'd0, cnv_start}, 8'h00);
    rd_reg(2'd0, v); chk("R1 ctl", v, 8'h1F);
    rd_reg(2'd1, v); chk("R1 data", v, 8'h00);
    exp_data = 8'h00;

    // table walk: R7 start decode, R3 flag write ignored, R8 aborts
    for (int k = 0; k < NV; k++) begin
      wr_reg(2'd0, VEC[k][16:9]);
      chk("R7 start", {7'd0, cnv_start}, {7'd0, VEC[k][0]});
      if (VEC[k][0]) chk("R7 chan", {6'd0, cnv_chan}, {6'd0, VEC[k][10:9]});
      rd_reg(2'd0, v);
      chk("R3 ctl readback", v, VEC[k][8:1]);
    end
    wr_reg(2'd0, 8'h1F);
    tick(30);
    rd_reg(2'd1, v); chk("R8 aborted results dropped", v, exp_data);

    // R3 flag with interrupts off, R6 single shot
    wr_reg(2'd0, 8'h01);
    wait_done(); e = m_res; tick();
    rd_reg(2'd0, v); chk("R3 flag set", v, 8'h81);
    rd_reg(2'd0, v); chk("R3 flag held over ctl read", v, 8'h81);
    rd_reg(2'd1, v); chk("R3 data", v, e); exp_data = e;
    rd_reg(2'd0, v); chk("R3 flag cleared", v, 8'h01);
    s0 = n_start; tick(40);
    chk("R6 single shot", 8'(n_start - s0), 8'h00);

    // R4 interrupt mode, R5 read clear
    wr_reg(2'd0, 8'h42);
    wait_done(); e = m_res; tick();
    chk("R4 irq raised", {7'd0, irq}, 8'h01);
    rd_reg(2'd0, v); chk("R4 flag masked", v, 8'h42);
    rd_reg(2'd1, v); chk("R4 data", v, e); exp_data = e;
    chk("R5 irq cleared by read", {7'd0, irq}, 8'h00);

    // R5 write clear
    wr_reg(2'd0, 8'h43);
    wait_done(); e = m_res; tick(); exp_data = e;
    chk("R5 irq set", {7'd0, irq}, 8'h01);
    wr_reg(2'd0, 8'h5F);
    chk("R5 irq cleared by write", {7'd0, irq}, 8'h00);

    // R6 continuous
    wr_reg(2'd0, 8'h20);
    for (int k = 0; k < 3; k++) begin
      wait_done(); e = m_res; tick();
      chk("R6 restart", {7'd0, cnv_start}, 8'h01);
      rd_reg(2'd1, v); chk("R6 data update", v, e); exp_data = e;
    end
    wr_reg(2'd0, 8'h1F);
    tick(20);

    // R9 read coincides with done
    wr_reg(2'd0, 8'h01);
    wait_done(); e = m_res;
    rd_reg(2'd1, v); chk("R9 old data on read", v, exp_data);
    rd_reg(2'd0, v); chk("R9 flag kept", v, 8'h81);
    rd_reg(2'd1, v); chk("R9 new data", v, e); exp_data = e;

    // R9 in interrupt mode
    wr_reg(2'd0, 8'h43);
    wait_done(); e = m_res;
    rd_reg(2'd1, v); chk("R9 old data irq", v, exp_data);
    chk("R9 irq kept", {7'd0, irq}, 8'h01);
    rd_reg(2'd1, v); chk("R9 new data irq", v, e); exp_data = e;
    chk("R5 irq cleared", {7'd0, irq}, 8'h00);

    // R8 write coincides with done
    wr_reg(2'd0, 8'h42);
    wait_done();
    wr_reg(2'd0, 8'h1F);
    chk("R8 irq after collision", {7'd0, irq}, 8'h00);
    rd_reg(2'd0, v); chk("R8 no flag", v, 8'h1F);
    rd_reg(2'd1, v); chk("R8 data kept", v, exp_data);

    // R8 abort and restart on another input
    wr_reg(2'd0, 8'h01);
    tick(5);
    wr_reg(2'd0, 8'h02);
    wait_done(); e = m_res; tick();
    chk("R8 restart channel", {6'd0, e[7:6]}, 8'h02);
    rd_reg(2'd0, v); chk("R8 flag after restart", v, 8'h82);
    rd_reg(2'd1, v); chk("R8 restart data", v, e); exp_data = e;

    // R8/R10 abort to idle, stale done ignored
    wr_reg(2'd0, 8'h03);
    tick(5);
    wr_reg(2'd0, 8'h1F);
    tick(30);
    rd_reg(2'd0, v); chk("R10 stale done no flag", v, 8'h1F);
    rd_reg(2'd1, v); chk("R10 stale done no data", v, exp_data);

    // R10 stray done pulse
    spur = 1'b1; tick(); spur = 1'b0; tick();
    chk("R10 stray no irq", {7'd0, irq}, 8'h00);
    rd_reg(2'd1, v); chk("R10 stray no data", v, exp_data);

    // R2 address map
    wr_reg(2'd1, 8'hAA);
    rd_reg(2'd1, v); chk("R2 data not writable", v, exp_data);
    wr_reg(2'd2, 8'h00);
    chk("R2 other write no start", {7'd0, cnv_start}, 8'h00);
    rd_reg(2'd2, v); chk("R2 unmapped reads zero", v, 8'h00);
    tick(2);
    chk("R2 rdata held", bus_rdata, 8'h00);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule